// File: doc/BRIEF.md
# Instruction Prefetch Queue Unit

This block is the fetch-side front end of a small processor. It keeps a six-byte first-in, first-out store of instruction bytes ahead of the execution side. It forms 20-bit physical addresses from a 16-bit code segment and a 16-bit instruction offset. It reads code one 16-bit word at a time through a simple request/acknowledge memory port. The consumer takes the bytes one at a time from the head of the queue.

The execution side can ask for an operand access on the same memory port. When both are eligible, an operand access wins over a new prefetch. A prefetch that is already in flight is always allowed to finish first. A jump redirect loads a new segment and offset, empties the queue, throws away any code word still in flight, and starts fetching again at the target. A registered two-bit status code reports what the queue did in the previous cycle.

Top module: `ipq_prefetch_unit`

## Requirements
- R1: Instruction bytes leave the queue in the order of their addresses. The queue never holds more than 6 bytes.
- R2: Every code fetch requests the word at an even physical address. The low data bits [7:0] carry the byte at that even address and go into the queue first. Bits [15:8] follow.
- R3: A code fetch is launched only when at least 2 bytes of the queue are free and no operand request is pending. With 0 or 1 free bytes, the memory port stays idle.
- R4: When an operand request and an eligible prefetch are both waiting on an idle port, the operand access is issued first, at the address given on `op_addr_i`.
- R5: A request is held, with a stable address and type, until it is acknowledged. An operand request that arrives during a code fetch is served immediately after that fetch.
- R6: `byte_valid_o` is low whenever the queue is empty. A read strobe given while the queue is empty takes no byte and has no effect.
- R7: A redirect empties the queue by the next cycle. It drops the data of any code fetch in flight, and the next byte delivered is the byte at the new target.
- R8: The physical address is segment × 16 + offset, taken modulo 2^20. For example, 1234h:0020h gives 12360h, and FFFFh:FFF0h gives 0FFE0h.
- R9: The code offset advances by the number of bytes queued from each fetch, and it wraps within 16 bits.
- R10: `qstat_o` shows, one cycle after the event, one of four codes: 10 after a redirect, 01 after taking a byte with `byte_first_i` high, 11 after taking any other byte, and 00 otherwise.
- R11: When the target offset is odd, the first fetch reads the even word that contains it and queues only its upper byte.
- R12: After reset, the code segment is FFFFh and the offset is 0000h, so the first fetch is at FFFF0h. The queue is empty and `qstat_o` is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| redirect_i | input | 1 | Jump redirect strobe |
| redirect_seg_i | input | 16 | Target code segment |
| redirect_off_i | input | 16 | Target code offset |
| op_req_i | input | 1 | Operand access request, held until `op_done_o` |
| op_addr_i | input | 20 | Operand physical address |
| op_done_o | output | 1 | Operand access acknowledged this cycle |
| mem_req_o | output | 1 | Memory request valid |
| mem_is_op_o | output | 1 | Request is an operand access (0 = code fetch) |
| mem_addr_o | output | 20 | Memory physical address |
| mem_ack_i | input | 1 | Memory acknowledge, completes the request |
| mem_rdata_i | input | 16 | Memory read word |
| byte_valid_o | output | 1 | Queue head holds a byte |
| byte_o | output | 8 | Queue head byte |
| byte_rd_i | input | 1 | Consumer takes the head byte |
| byte_first_i | input | 1 | The byte taken is an opcode's first byte |
| qstat_o | output | 2 | Queue status code |

## Verification
The byte stream is checked against an address-derived memory pattern under four kinds of target:
- the reset target, which crosses the top of the address space;
- an even target;
- an odd target, which separates upper-byte-only queueing from whole-word queueing;
- a target whose offset wraps within the segment, which separates modulo-2^20 address formation from a plain 21-bit sum.

Holding back the consumer shows whether the port idles at zero and at one free byte and resumes at two. Raising an operand request during a code fetch, and separately on an idle port, separates "complete the fetch first" from "operand beats a new prefetch". Redirecting in the middle of a fetch shows whether stale data is discarded.

// File: rtl/ipq_pkg.sv
`timescale 1ns / 1ps
package ipq_pkg;
    typedef enum logic [1:0] {
        BUS_IDLE  = 2'd0,
        BUS_FETCH = 2'd1,
        BUS_OPER  = 2'd2
    } bus_st_e;

    typedef enum logic [1:0] {
        QS_NONE  = 2'b00,
        QS_FIRST = 2'b01,
        QS_FLUSH = 2'b10,
        QS_NEXT  = 2'b11
    } qstat_e;
endpackage

// File: rtl/ipq_addr_gen.sv
`timescale 1ns / 1ps
module ipq_addr_gen #(
    parameter int SEG_W = 16,
    parameter int OFF_W = 16,
    parameter int PA_W  = 20,
    parameter int SHIFT = 4
) (
    input  logic [SEG_W-1:0] seg_i,
    input  logic [OFF_W-1:0] off_i,
    output logic [PA_W-1:0]  phys_o
);
    localparam int RAW_W = (SEG_W + SHIFT > OFF_W) ? SEG_W + SHIFT : OFF_W;
    localparam int SUM_W = ((RAW_W > PA_W) ? RAW_W : PA_W) + 1;

    logic [SUM_W-1:0] base_w;
    logic [SUM_W-1:0] offs_w;
    logic [SUM_W-1:0] sum_w;

    // Segment is a paragraph number; the sum is truncated to the address width.
    assign base_w = SUM_W'(seg_i) << SHIFT;
    assign offs_w = SUM_W'(off_i);
    assign sum_w  = base_w + offs_w;
    assign phys_o = sum_w[PA_W-1:0];
endmodule

// File: rtl/ipq_fifo.sv
`timescale 1ns / 1ps
module ipq_fifo #(
    parameter int DEPTH = 6,
    parameter int DW    = 8,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush_i,
    input  logic [1:0]    push_n_i,
    input  logic [DW-1:0] push_b0_i,
    input  logic [DW-1:0] push_b1_i,
    input  logic          pop_i,
    output logic [DW-1:0] head_o,
    output logic [CW-1:0] count_o
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [PW-1:0]            rd;
        logic [PW-1:0]            wr;
        logic [CW-1:0]            cnt;
    } fifo_t;

    fifo_t cur_q, nxt_d;
    logic  do_pop;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_comb begin
        nxt_d  = cur_q;
        do_pop = pop_i && (cur_q.cnt != '0);
        if (flush_i) begin
            nxt_d.rd  = '0;
            nxt_d.wr  = '0;
            nxt_d.cnt = '0;
        end else begin
            if (push_n_i != 2'd0) begin
                nxt_d.mem[cur_q.wr] = push_b0_i;
            end
            if (push_n_i == 2'd2) begin
                nxt_d.mem[step(cur_q.wr)] = push_b1_i;
                nxt_d.wr = step(step(cur_q.wr));
            end else if (push_n_i == 2'd1) begin
                nxt_d.wr = step(cur_q.wr);
            end
            if (do_pop) begin
                nxt_d.rd = step(cur_q.rd);
            end
            nxt_d.cnt = cur_q.cnt + CW'(push_n_i) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign head_o  = cur_q.mem[cur_q.rd];
    assign count_o = cur_q.cnt;

    // R1: occupancy never exceeds the queue size
    p_count_cap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.cnt <= CW'(DEPTH));

    // R3: a returning word always finds room
    p_push_room_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (push_n_i != 2'd0) |-> (int'(cur_q.cnt) + int'(push_n_i) <= DEPTH));

    // R6: a read on an empty queue leaves it empty
    p_empty_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.cnt == '0 && push_n_i == 2'd0 && !flush_i) |=> (cur_q.cnt == '0));
endmodule

// File: rtl/ipq_bus_ctl.sv
`timescale 1ns / 1ps
module ipq_bus_ctl
    import ipq_pkg::*;
#(
    parameter int             DEPTH   = 6,
    parameter int             SEG_W   = 16,
    parameter int             OFF_W   = 16,
    parameter int             PA_W    = 20,
    parameter int             CW      = $clog2(DEPTH + 1),
    parameter logic [SEG_W-1:0] RST_SEG = '1,
    parameter logic [OFF_W-1:0] RST_OFF = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             redirect_i,
    input  logic [SEG_W-1:0] tgt_seg_i,
    input  logic [OFF_W-1:0] tgt_off_i,
    input  logic             op_req_i,
    input  logic [PA_W-1:0]  op_addr_i,
    output logic             op_done_o,
    output logic             mem_req_o,
    output logic             mem_is_op_o,
    output logic [PA_W-1:0]  mem_addr_o,
    input  logic             mem_ack_i,
    input  logic [15:0]      mem_rdata_i,
    input  logic [CW-1:0]    q_count_i,
    output logic             flush_o,
    output logic [1:0]       push_n_o,
    output logic [7:0]       push_b0_o,
    output logic [7:0]       push_b1_o
);
    typedef struct packed {
        bus_st_e          st;
        logic [SEG_W-1:0] seg;
        logic [OFF_W-1:0] off;
        logic [PA_W-1:0]  addr;
        logic             discard;
    } ctl_t;

    ctl_t            cur_q, nxt_d;
    logic [PA_W-1:0] fetch_pa;
    int              free_room;

    ipq_addr_gen #(
        .SEG_W (SEG_W),
        .OFF_W (OFF_W),
        .PA_W  (PA_W),
        .SHIFT (4)
    ) u_addr (
        .seg_i  (cur_q.seg),
        .off_i  (cur_q.off),
        .phys_o (fetch_pa)
    );

    always_comb begin
        nxt_d     = cur_q;
        push_n_o  = 2'd0;
        push_b0_o = mem_rdata_i[7:0];
        push_b1_o = mem_rdata_i[15:8];
        free_room = DEPTH - int'(q_count_i);
        unique case (cur_q.st)
            BUS_IDLE: begin
                if (op_req_i) begin
                    nxt_d.st   = BUS_OPER;
                    nxt_d.addr = op_addr_i;
                end else if (!redirect_i && free_room >= 2) begin
                    nxt_d.st   = BUS_FETCH;
                    nxt_d.addr = {fetch_pa[PA_W-1:1], 1'b0};
                end
            end
            BUS_FETCH: begin
                if (mem_ack_i) begin
                    nxt_d.st      = BUS_IDLE;
                    nxt_d.discard = 1'b0;
                    if (!cur_q.discard && !redirect_i) begin
                        if (cur_q.off[0]) begin
                            push_n_o  = 2'd1;
                            push_b0_o = mem_rdata_i[15:8];
                        end else begin
                            push_n_o  = 2'd2;
                        end
                        nxt_d.off = cur_q.off + OFF_W'(push_n_o);
                    end
                end else if (redirect_i) begin
                    nxt_d.discard = 1'b1;
                end
            end
            BUS_OPER: begin
                if (mem_ack_i) begin
                    nxt_d.st = BUS_IDLE;
                end
            end
            default: nxt_d.st = BUS_IDLE;
        endcase
        if (redirect_i) begin
            nxt_d.seg = tgt_seg_i;
            nxt_d.off = tgt_off_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q         <= '0;
            cur_q.st      <= BUS_IDLE;
            cur_q.seg     <= RST_SEG;
            cur_q.off     <= RST_OFF;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign mem_req_o   = (cur_q.st != BUS_IDLE);
    assign mem_is_op_o = (cur_q.st == BUS_OPER);
    assign mem_addr_o  = cur_q.addr;
    assign op_done_o   = (cur_q.st == BUS_OPER) && mem_ack_i;
    assign flush_o     = redirect_i;

    // R2: code fetches are word aligned
    p_even_fetch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_is_op_o) |-> !mem_addr_o[0]);

    // R3: a live fetch always has two free bytes waiting for it
    p_fetch_room_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_is_op_o && !cur_q.discard) |-> (int'(q_count_i) <= DEPTH - 2));

    // R4: a pending operand on an idle port is issued next
    p_op_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_req_o && op_req_i) |=> (mem_req_o && mem_is_op_o));

    // R5: request held stable until acknowledged
    p_hold_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_is_op_o)));
endmodule

// File: rtl/ipq_prefetch_unit.sv
`timescale 1ns / 1ps
module ipq_prefetch_unit
    import ipq_pkg::*;
#(
    parameter int DEPTH = 6,
    parameter int SEG_W = 16,
    parameter int OFF_W = 16,
    parameter int PA_W  = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             redirect_i,
    input  logic [SEG_W-1:0] redirect_seg_i,
    input  logic [OFF_W-1:0] redirect_off_i,
    input  logic             op_req_i,
    input  logic [PA_W-1:0]  op_addr_i,
    output logic             op_done_o,
    output logic             mem_req_o,
    output logic             mem_is_op_o,
    output logic [PA_W-1:0]  mem_addr_o,
    input  logic             mem_ack_i,
    input  logic [15:0]      mem_rdata_i,
    output logic             byte_valid_o,
    output logic [7:0]       byte_o,
    input  logic             byte_rd_i,
    input  logic             byte_first_i,
    output logic [1:0]       qstat_o
);
    localparam int CW = $clog2(DEPTH + 1);

    logic [CW-1:0] q_count;
    logic          flush;
    logic [1:0]    push_n;
    logic [7:0]    push_b0;
    logic [7:0]    push_b1;
    logic          take;
    qstat_e        qs_d, qs_q;

    ipq_bus_ctl #(
        .DEPTH (DEPTH),
        .SEG_W (SEG_W),
        .OFF_W (OFF_W),
        .PA_W  (PA_W),
        .CW    (CW)
    ) u_bus (
        .clk         (clk),
        .rst_n       (rst_n),
        .redirect_i  (redirect_i),
        .tgt_seg_i   (redirect_seg_i),
        .tgt_off_i   (redirect_off_i),
        .op_req_i    (op_req_i),
        .op_addr_i   (op_addr_i),
        .op_done_o   (op_done_o),
        .mem_req_o   (mem_req_o),
        .mem_is_op_o (mem_is_op_o),
        .mem_addr_o  (mem_addr_o),
        .mem_ack_i   (mem_ack_i),
        .mem_rdata_i (mem_rdata_i),
        .q_count_i   (q_count),
        .flush_o     (flush),
        .push_n_o    (push_n),
        .push_b0_o   (push_b0),
        .push_b1_o   (push_b1)
    );

    ipq_fifo #(
        .DEPTH (DEPTH),
        .DW    (8),
        .CW    (CW)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush_i   (flush),
        .push_n_i  (push_n),
        .push_b0_i (push_b0),
        .push_b1_i (push_b1),
        .pop_i     (byte_rd_i),
        .head_o    (byte_o),
        .count_o   (q_count)
    );

    assign byte_valid_o = (q_count != '0);
    assign take         = byte_rd_i && byte_valid_o && !redirect_i;

    always_comb begin
        if (redirect_i) begin
            qs_d = QS_FLUSH;
        end else if (take) begin
            qs_d = byte_first_i ? QS_FIRST : QS_NEXT;
        end else begin
            qs_d = QS_NONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            qs_q <= QS_NONE;
        end else begin
            qs_q <= qs_d;
        end
    end

    assign qstat_o = qs_q;

    // R7: redirect leaves nothing to consume on the next cycle
    p_flush_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_i |=> !byte_valid_o);

    // R10: redirect is reported with the flush code
    p_flush_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_i |=> (qstat_o == 2'b10));
endmodule

// File: tb/ipq_prefetch_unit_bench.sv
`timescale 1ns / 1ps
module ipq_prefetch_unit_bench;
    localparam int HALF = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        redirect_i = 1'b0;
    logic [15:0] redirect_seg_i = '0;
    logic [15:0] redirect_off_i = '0;
    logic        op_req_i = 1'b0;
    logic [19:0] op_addr_i = '0;
    logic        op_done_o;
    logic        mem_req_o;
    logic        mem_is_op_o;
    logic [19:0] mem_addr_o;
    logic        mem_ack = 1'b0;
    logic [15:0] mem_rdata = '0;
    logic        byte_valid_o;
    logic [7:0]  byte_o;
    logic        byte_rd_i = 1'b0;
    logic        byte_first_i = 1'b0;
    logic [1:0]  qstat_o;

    int          n_chk = 0;
    int          n_bad = 0;
    int          lat = 1;
    logic [7:0]  exp_q[$];
    logic [19:0] log_addr[$];
    bit          log_op[$];

    always #HALF clk = ~clk;

    ipq_prefetch_unit u_ipq_prefetch_unit (
        .clk            (clk),
        .rst_n          (rst_n),
        .redirect_i     (redirect_i),
        .redirect_seg_i (redirect_seg_i),
        .redirect_off_i (redirect_off_i),
        .op_req_i       (op_req_i),
        .op_addr_i      (op_addr_i),
        .op_done_o      (op_done_o),
        .mem_req_o      (mem_req_o),
        .mem_is_op_o    (mem_is_op_o),
        .mem_addr_o     (mem_addr_o),
        .mem_ack_i      (mem_ack),
        .mem_rdata_i    (mem_rdata),
        .byte_valid_o   (byte_valid_o),
        .byte_o         (byte_o),
        .byte_rd_i      (byte_rd_i),
        .byte_first_i   (byte_first_i),
        .qstat_o        (qstat_o)
    );

    function automatic logic [7:0] mbyte(input logic [19:0] a);
        return a[7:0] ^ {a[19:16], a[11:8]} ^ 8'h5A;
    endfunction

    function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] o);
        return {s, 4'h0} + {4'h0, o};
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // memory responder: acknowledges after lat extra cycles, logs each transfer
    initial begin
        int w;
        w = 0;
        forever begin
            @(posedge clk);
            #1;
            if (mem_ack) begin
                mem_ack = 1'b0;
                w = 0;
            end else if (rst_n && mem_req_o) begin
                if (w >= lat) begin
                    mem_ack = 1'b1;
                    log_addr.push_back(mem_addr_o);
                    log_op.push_back(mem_is_op_o);
                    mem_rdata = mem_is_op_o ? 16'hBEEF
                                            : {mbyte(mem_addr_o + 20'd1), mbyte(mem_addr_o)};
                end else begin
                    w++;
                end
            end
        end
    end

    // driver: redirect and load the expected byte stream for the target
    task automatic redirect_to(input logic [15:0] s, input logic [15:0] o, input int n);
        @(negedge clk);
        redirect_i = 1'b1;
        redirect_seg_i = s;
        redirect_off_i = o;
        exp_q.delete();
        for (int k = 0; k < n; k++) begin
            exp_q.push_back(mbyte(phys(s, o + 16'(k))));
        end
        @(negedge clk);
        redirect_i = 1'b0;
        chk("R10", "status after redirect", 32'(qstat_o), 32'h2);
        chk("R7", "queue empty after redirect", 32'(byte_valid_o), 32'h0);
    endtask

    // monitor: pops expected bytes and compares as the design delivers them
    task automatic consume(input int n, input bit first);
        for (int i = 0; i < n; i++) begin
            logic [7:0] e;
            while (!byte_valid_o) @(negedge clk);
            e = exp_q.pop_front();
            chk("R1", "byte stream", 32'(byte_o), 32'(e));
            byte_rd_i = 1'b1;
            byte_first_i = first && (i == 0);
            @(negedge clk);
            byte_rd_i = 1'b0;
            byte_first_i = 1'b0;
            chk("R10", "status after take", 32'(qstat_o), (first && i == 0) ? 32'h1 : 32'h3);
        end
    endtask

    task automatic wait_quiet();
        int q;
        q = 0;
        while (q < 3) begin
            @(negedge clk);
            q = mem_req_o ? 0 : q + 1;
        end
    endtask

    task automatic wait_log(input int n);
        while (log_addr.size() < n) @(negedge clk);
    endtask

    task automatic wait_op_ack();
        while (!(mem_ack && mem_is_op_o)) @(negedge clk);
        op_req_i = 1'b0;
    endtask

    initial begin
        #(2 * HALF * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int nlog;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R12: reset state
        chk("R12", "byte_valid at reset", 32'(byte_valid_o), 32'h0);
        chk("R12", "qstat at reset", 32'(qstat_o), 32'h0);
        chk("R12", "mem_req at reset", 32'(mem_req_o), 32'h0);
        for (int k = 0; k < 40; k++) begin
            exp_q.push_back(mbyte(phys(16'hFFFF, 16'(k))));
        end

        // R1 R2 R9: stream from the reset target across the top of memory
        consume(8, 1'b1);
        wait_log(2);
        chk("R12", "first fetch address", 32'(log_addr[0]), 32'hFFFF0);
        chk("R2", "first fetch is code", 32'(log_op[0]), 32'h0);
        chk("R9", "second fetch address", 32'(log_addr[1]), 32'hFFFF2);

        // R3: full queue and one free byte both leave the port idle
        repeat (30) @(negedge clk);
        nlog = log_addr.size();
        repeat (20) @(negedge clk);
        chk("R3", "no fetch with full queue", 32'(log_addr.size()), 32'(nlog));
        chk("R3", "queue holds bytes", 32'(byte_valid_o), 32'h1);
        consume(1, 1'b0);
        repeat (20) @(negedge clk);
        chk("R3", "no fetch with one free byte", 32'(log_addr.size()), 32'(nlog));

        // R4: second free byte and operand request arrive together; operand wins
        consume(1, 1'b0);
        op_req_i = 1'b1;
        op_addr_i = 20'h0ABCD;
        wait_op_ack();
        chk("R4", "operand issued before prefetch", 32'(log_op[nlog]), 32'h1);
        chk("R4", "operand address", 32'(log_addr[nlog]), 32'h0ABCD);
        consume(6, 1'b0);

        // R8: even target
        wait_quiet();
        nlog = log_addr.size();
        redirect_to(16'h1234, 16'h0020, 24);
        consume(7, 1'b1);
        chk("R8", "fetch at 1234:0020", 32'(log_addr[nlog]), 32'h12360);

        // R11: odd target queues only the upper byte first
        wait_quiet();
        nlog = log_addr.size();
        redirect_to(16'h2000, 16'h0005, 24);
        consume(5, 1'b1);
        chk("R11", "odd target word address", 32'(log_addr[nlog]), 32'h20004);
        chk("R9", "fetch after odd target", 32'(log_addr[nlog + 1]), 32'h20006);

        // R8 R9: address wraps modulo 2^20, offset wraps within the segment
        wait_quiet();
        nlog = log_addr.size();
        redirect_to(16'hFFFF, 16'hFFF0, 40);
        consume(20, 1'b1);
        chk("R8", "wrapped physical address", 32'(log_addr[nlog]), 32'h0FFE0);

        // R7: redirect during an in-flight fetch discards its data
        lat = 6;
        while (!(mem_req_o && !mem_is_op_o && !mem_ack)) @(negedge clk);
        nlog = log_addr.size();
        redirect_to(16'h0100, 16'h0000, 24);
        // R6: reads on an empty queue take nothing
        byte_rd_i = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R6", "still empty after reads", 32'(byte_valid_o), 32'h0);
        chk("R6", "empty read gives no status", 32'(qstat_o), 32'h0);
        byte_rd_i = 1'b0;
        consume(6, 1'b1);
        chk("R7", "old fetch finished first", 32'(log_addr[nlog] != 20'h01000), 32'h1);
        chk("R7", "restart at target", 32'(log_addr[nlog + 1]), 32'h01000);

        // R5: operand raised during a fetch is served right after it
        consume(2, 1'b0);
        while (!(mem_req_o && !mem_is_op_o && !mem_ack)) @(negedge clk);
        nlog = log_addr.size();
        op_req_i = 1'b1;
        op_addr_i = 20'h54321;
        wait_op_ack();
        chk("R5", "fetch completes first", 32'(log_op[nlog]), 32'h0);
        chk("R5", "operand served next", 32'(log_op[nlog + 1]), 32'h1);
        chk("R5", "operand address", 32'(log_addr[nlog + 1]), 32'h54321);
        consume(6, 1'b0);

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule